// File: doc/BRIEF.md
# Multi-Mode Timer Compare Unit

This block is an up/down timer counter feeding two compare channels. Each channel turns the running count, its compare value and its mode into a registered reference level. Channel 0 can also pair its reference with channel 1's to form a combined output. The modes are:

- plain hold, set, clear and toggle on match;
- force low and force high;
- two PWM polarities;
- retriggerable one-pulse windows opened by an external trigger;
- OR/AND combination of the two references;
- selection of one reference or the other by count direction.

A repetition counter stretches the interval between update events over several counter wraps.

Software programs the unit through a plain register write port. Period, compare values, modes and repetition count go to shadow copies and only reach the active logic on an update event, so a period never shows a half-applied setting. Run and direction take effect at once. No streaming data passes through the block: every pin is a plain control or status level, sampled on the rising clock edge, and there is no back-pressure. All references and the combined output are registered, so each reflects the count value of the previous cycle.

Top module: `tmr_ocu`

## Requirements
- R1: After the active-low asynchronous reset, the count, both references, the combined output and the update pulse are 0, and both channels are in the hold mode (code 0).
- R2: Writing address 5 loads control: bit 0 is run and bit 1 selects down counting. This takes effect at the next edge. While running up, the count steps by one and wraps from the active period to 0. While running down, it steps down and wraps from 0 to the active period. With run clear, the count holds.
- R3: A wrap reached with the repetition down-counter at zero raises an update event, which reloads the repetition counter from its shadow (address 4). Otherwise a wrap only decrements the repetition counter, so updates occur every (repetition+1) wraps. `update_o` pulses for one cycle right after each update event.
- R4: Writes to the period (address 0), compare 0 (address 1), compare 1 (address 2), modes (address 3, channel 0 in bits 3:0 and channel 1 in bits 7:4) and repetition (address 4) go to shadows. They are copied to the active set only on an update event. `upd_force_i` raises an update at once and restarts the count at 0 (up) or at the new period (down).
- R5: PWM-A (code 6) is high when counting up with count < compare, and high when counting down with count <= compare. PWM-B (code 7) is its complement.
- R6: Set-on-match (1), clear-on-match (2) and toggle-on-match (3) act only when the running count equals the compare value. Force-low (4) and force-high (5) drive a fixed level. Hold (0) keeps the last level.
- R7: One-pulse A (code 8) idles high when counting up and low when counting down. While its window is open it follows PWM-A. The window opens on a trigger and closes at the next update event.
- R8: One-pulse B (code 9) is the complement of one-pulse A: it idles low up and high down, and follows PWM-B inside the window.
- R9: While either channel is in a one-pulse mode, a trigger (re)opens the window and restarts the count without an update event: to 0 when counting up, or to the active period when counting down. A trigger inside an open window restarts it.
- R10: Channel-0 code 12 makes reference 0 behave as PWM-A and the combined output as reference 0 OR reference 1. Code 13 makes reference 0 behave as PWM-B and the combined output as their AND.
- R11: Channel-0 codes 14 and 15 make reference 0 behave as PWM-A or PWM-B respectively. The combined output carries reference 0 while counting up and reference 1 while counting down. In any other channel-0 mode, the combined output equals reference 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| trig_i | input | 1 | External trigger for one-pulse modes, one cycle per event |
| upd_force_i | input | 1 | Immediate update request |
| cnt_o | output | CNT_W | Current count |
| dir_o | output | 1 | 1 while counting down |
| update_o | output | 1 | One-cycle pulse after an update event |
| ref_o | output | 2 | Channel reference levels |
| comb_o | output | 1 | Combined reference output |

## Verification
The hardest case to reach is a retrigger landing inside an already open one-pulse window, in each direction. The one-pulse level is only visible for as long as the window stays open, and the window closes at the first update. The stimulus therefore forces an update to place the count, watches `cnt_o` until a chosen value, and fires the trigger. It then watches for a second chosen value and fires again before the wrap, so the count restart and the widened window can be seen. A cycle model driven by the same inputs is compared against every output on every cycle, while tallied high-cycle counts per period check the level modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [3:0] {
    OC_HOLD   = 4'd0,
    OC_SET    = 4'd1,
    OC_CLR    = 4'd2,
    OC_TOG    = 4'd3,
    OC_LOW    = 4'd4,
    OC_HIGH   = 4'd5,
    OC_PWMA   = 4'd6,
    OC_PWMB   = 4'd7,
    OC_OPA    = 4'd8,
    OC_OPB    = 4'd9,
    OC_CMBOR  = 4'd12,
    OC_CMBAND = 4'd13,
    OC_ASYA   = 4'd14,
    OC_ASYB   = 4'd15
  } oc_mode_e;

  localparam int MODE_W = 4;
  localparam int NCH    = 2;

  localparam logic [2:0] ADR_PERIOD = 3'd0;
  localparam logic [2:0] ADR_CMP0   = 3'd1;
  localparam logic [2:0] ADR_CMP1   = 3'd2;
  localparam logic [2:0] ADR_MODES  = 3'd3;
  localparam logic [2:0] ADR_REP    = 3'd4;
  localparam logic [2:0] ADR_CTRL   = 3'd5;

  function automatic logic is_one_pulse(input logic [MODE_W-1:0] m);
    return (m == OC_OPA) || (m == OC_OPB);
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [2:0]                     addr,
  input  logic [CNT_W-1:0]               wdata,
  input  logic                           upd,
  output logic [CNT_W-1:0]               period_s,
  output logic [CNT_W-1:0]               period_a,
  output logic [NCH-1:0][CNT_W-1:0]      cmp_a,
  output logic [NCH-1:0][MODE_W-1:0]     mode_a,
  output logic [REP_W-1:0]               rep_s,
  output logic                           run,
  output logic                           down
);
  localparam int MODES_W = NCH * MODE_W;

  logic [NCH-1:0][CNT_W-1:0]  cmp_s;
  logic [NCH-1:0][MODE_W-1:0] mode_s;

  // shadow side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_s <= '0;
      rep_s    <= '0;
      mode_s   <= '0;
      run      <= 1'b0;
      down     <= 1'b0;
    end else if (we) begin
      case (addr)
        ADR_PERIOD: period_s <= wdata;
        ADR_MODES:  mode_s   <= wdata[MODES_W-1:0];
        ADR_REP:    rep_s    <= wdata[REP_W-1:0];
        ADR_CTRL: begin
          run  <= wdata[0];
          down <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_cmp_shadow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cmp_s[i] <= '0;
        else if (we && addr == ADR_CMP0 + 3'(i))
          cmp_s[i] <= wdata;
      end
    end
  endgenerate

  // active side, loaded on update only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_a <= '0;
      cmp_a    <= '0;
      mode_a   <= '0;
    end else if (upd) begin
      period_a <= period_s;
      cmp_a    <= cmp_s;
      mode_a   <= mode_s;
    end
  end

  a_r4_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(period_a) && $stable(cmp_a) && $stable(mode_a)));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             down,
  input  logic             restart,
  input  logic             force_upd,
  input  logic [CNT_W-1:0] period_a,
  input  logic [CNT_W-1:0] period_s,
  input  logic [REP_W-1:0] rep_s,
  output logic [CNT_W-1:0] cnt,
  output logic             upd,
  output logic             update_q
);
  logic [REP_W-1:0] rep_cnt;
  logic             at_end;
  logic             wrap;

  assign at_end = down ? (cnt == '0) : (cnt == period_a);
  assign wrap   = run && !restart && at_end;
  assign upd    = force_upd || (wrap && rep_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (force_upd)
      cnt <= down ? period_s : '0;
    else if (restart)
      cnt <= down ? period_a : '0;
    else if (wrap)
      cnt <= down ? (upd ? period_s : period_a) : '0;
    else if (run)
      cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_cnt  <= '0;
      update_q <= 1'b0;
    end else begin
      update_q <= upd;
      if (upd)
        rep_cnt <= rep_s;
      else if (wrap)
        rep_cnt <= rep_cnt - 1'b1;
    end
  end

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period_a);

  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !down && !restart && !force_upd && cnt != period_a)
    |=> cnt == $past(cnt) + 1'b1);

  a_r3_rep_reload: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> rep_cnt == $past(rep_s));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  cmp,
  input  logic [MODE_W-1:0] mode,
  input  logic              down,
  input  logic              run,
  input  logic              open,
  output logic              ref_n,
  output logic              ref_q
);
  logic lt, gt, match, pwm_a;

  assign lt    = cnt < cmp;
  assign gt    = cnt > cmp;
  assign match = run && !lt && !gt;
  assign pwm_a = down ? !gt : lt;

  always_comb begin
    case (oc_mode_e'(mode))
      OC_HOLD:                      ref_n = ref_q;
      OC_SET:                       ref_n = match | ref_q;
      OC_CLR:                       ref_n = !match & ref_q;
      OC_TOG:                       ref_n = match ^ ref_q;
      OC_LOW:                       ref_n = 1'b0;
      OC_HIGH:                      ref_n = 1'b1;
      OC_PWMA, OC_CMBOR, OC_ASYA:   ref_n = pwm_a;
      OC_PWMB, OC_CMBAND, OC_ASYB:  ref_n = !pwm_a;
      OC_OPA:                       ref_n = open ? pwm_a  : !down;
      OC_OPB:                       ref_n = open ? !pwm_a : down;
      default:                      ref_n = ref_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_n;
  end

  a_r6_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OC_HIGH) |=> ref_q);

  a_r5_pwm_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OC_PWMA && !down) |=> ref_q == ($past(cnt) < $past(cmp)));

endmodule

// File: rtl/tmr_combine.sv
module tmr_combine
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ref_n,
  input  logic [MODE_W-1:0] mode0,
  input  logic              down,
  output logic              comb_q
);
  logic comb_n;

  always_comb begin
    case (oc_mode_e'(mode0))
      OC_CMBOR:         comb_n = ref_n[0] | ref_n[1];
      OC_CMBAND:        comb_n = ref_n[0] & ref_n[1];
      OC_ASYA, OC_ASYB: comb_n = down ? ref_n[1] : ref_n[0];
      default:          comb_n = ref_n[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) comb_q <= 1'b0;
    else        comb_q <= comb_n;
  end

  a_r10_or_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode0 == OC_CMBOR && ref_n[1]) |=> comb_q);

endmodule

// File: rtl/tmr_ocu.sv
module tmr_ocu
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             trig_i,
  input  logic             upd_force_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             update_o,
  output logic [1:0]       ref_o,
  output logic             comb_o
);
  logic [CNT_W-1:0]               period_s, period_a;
  logic [NCH-1:0][CNT_W-1:0]      cmp_a;
  logic [NCH-1:0][MODE_W-1:0]     mode_a;
  logic [REP_W-1:0]               rep_s;
  logic                           run, down, upd, restart, opm_any, open_q;
  logic [NCH-1:0]                 ref_n;

  tmr_regs #(.CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .upd(upd), .period_s(period_s), .period_a(period_a), .cmp_a(cmp_a),
    .mode_a(mode_a), .rep_s(rep_s), .run(run), .down(down)
  );

  assign opm_any = is_one_pulse(mode_a[0]) || is_one_pulse(mode_a[1]);
  assign restart = trig_i && opm_any;

  tmr_counter #(.CNT_W(CNT_W), .REP_W(REP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .down(down), .restart(restart),
    .force_upd(upd_force_i), .period_a(period_a), .period_s(period_s),
    .rep_s(rep_s), .cnt(cnt_o), .upd(upd), .update_q(update_o)
  );

  // one-pulse window: opened by trigger, closed by update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (restart) open_q <= 1'b1;
    else if (upd)     open_q <= 1'b0;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      tmr_chan #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_o), .cmp(cmp_a[i]), .mode(mode_a[i]),
        .down(down), .run(run), .open(open_q), .ref_n(ref_n[i]), .ref_q(ref_o[i])
      );
    end
  endgenerate

  tmr_combine u_comb (
    .clk(clk), .rst_n(rst_n), .ref_n(ref_n), .mode0(mode_a[0]),
    .down(down), .comb_q(comb_o)
  );

  assign dir_o = down;

  a_r9_restart_up: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && opm_any && !upd_force_i && !down) |=> cnt_o == '0);

  a_r7_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !restart) |=> !open_q);

endmodule

// File: tb/tb_tmr_ocu.sv
module tb_tmr_ocu;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic trig_i = 1'b0, upd_force_i = 1'b0;
  logic [W-1:0] cnt_o;
  logic dir_o, update_o, comb_o;
  logic [1:0] ref_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_ocu dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_i(trig_i), .upd_force_i(upd_force_i),
    .cnt_o(cnt_o), .dir_o(dir_o), .update_o(update_o), .ref_o(ref_o),
    .comb_o(comb_o)
  );

  // ---------------- cycle model built from the requirements ----------------
  logic [W-1:0] m_cnt, m_per_s, m_per_a;
  logic [W-1:0] m_cmp_s [2], m_cmp_a [2];
  logic [3:0]   m_md_s [2], m_md_a [2];
  logic [7:0]   m_rep_s, m_rep;
  logic m_run, m_dn, m_open, m_upd_o, m_comb;
  logic [1:0] m_ref;

  function automatic logic ref_fn(input logic [3:0] md, input logic [W-1:0] c,
                                  input logic [W-1:0] cp, input logic dn,
                                  input logic rn, input logic op, input logic cur);
    logic pa, hit;
    pa  = dn ? (c <= cp) : (c < cp);
    hit = rn && (c == cp);
    case (md)
      4'd0: return cur;
      4'd1: return hit ? 1'b1 : cur;
      4'd2: return hit ? 1'b0 : cur;
      4'd3: return hit ? !cur : cur;
      4'd4: return 1'b0;
      4'd5: return 1'b1;
      4'd6, 4'd12, 4'd14: return pa;
      4'd7, 4'd13, 4'd15: return !pa;
      4'd8: return op ? pa : !dn;
      4'd9: return op ? !pa : dn;
      default: return cur;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_per_s = '0; m_per_a = '0; m_rep_s = '0; m_rep = '0;
    for (int i = 0; i < 2; i++) begin
      m_cmp_s[i] = '0; m_cmp_a[i] = '0; m_md_s[i] = '0; m_md_a[i] = '0;
    end
    m_run = 0; m_dn = 0; m_open = 0; m_upd_o = 0; m_comb = 0; m_ref = '0;
  endtask

  task automatic model_edge();
    logic opm, rs, at_end, wr, up;
    logic [1:0] rn;
    logic cb;
    logic [W-1:0] cn;
    opm = (m_md_a[0] == 4'd8) || (m_md_a[0] == 4'd9) ||
          (m_md_a[1] == 4'd8) || (m_md_a[1] == 4'd9);
    rs = trig_i && opm;
    at_end = m_dn ? (m_cnt == 0) : (m_cnt == m_per_a);
    wr = m_run && !rs && at_end;
    up = upd_force_i || (wr && m_rep == 0);
    for (int i = 0; i < 2; i++)
      rn[i] = ref_fn(m_md_a[i], m_cnt, m_cmp_a[i], m_dn, m_run, m_open, m_ref[i]);
    case (m_md_a[0])
      4'd12: cb = rn[0] | rn[1];
      4'd13: cb = rn[0] & rn[1];
      4'd14, 4'd15: cb = m_dn ? rn[1] : rn[0];
      default: cb = rn[0];
    endcase
    if (upd_force_i) cn = m_dn ? m_per_s : '0;
    else if (rs) cn = m_dn ? m_per_a : '0;
    else if (wr) cn = m_dn ? (up ? m_per_s : m_per_a) : '0;
    else if (m_run) cn = m_dn ? m_cnt - 1 : m_cnt + 1;
    else cn = m_cnt;
    if (up) m_rep = m_rep_s; else if (wr) m_rep = m_rep - 1;
    if (rs) m_open = 1; else if (up) m_open = 0;
    if (up) begin
      m_per_a = m_per_s;
      for (int i = 0; i < 2; i++) begin m_cmp_a[i] = m_cmp_s[i]; m_md_a[i] = m_md_s[i]; end
    end
    m_cnt = cn; m_ref = rn; m_comb = cb; m_upd_o = up;
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: m_per_s = cfg_wdata;
        3'd1: m_cmp_s[0] = cfg_wdata;
        3'd2: m_cmp_s[1] = cfg_wdata;
        3'd3: begin m_md_s[0] = cfg_wdata[3:0]; m_md_s[1] = cfg_wdata[7:4]; end
        3'd4: m_rep_s = cfg_wdata[7:0];
        3'd5: begin m_run = cfg_wdata[0]; m_dn = cfg_wdata[1]; end
        default: ;
      endcase
    end
  endtask

  // ---------------- check helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_model();
    n_chk++;
    if (cnt_o !== m_cnt || ref_o !== m_ref || comb_o !== m_comb ||
        update_o !== m_upd_o || dir_o !== m_dn) begin
      n_bad++;
      $display("FAIL R2-trace actual cnt=%0d ref=%b comb=%b upd=%b expected cnt=%0d ref=%b comb=%b upd=%b",
               cnt_o, ref_o, comb_o, update_o, m_cnt, m_ref, m_comb, m_upd_o);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic force_upd();
    upd_force_i = 1; tick(); upd_force_i = 0;
  endtask

  task automatic trig();
    trig_i = 1; tick(); trig_i = 0;
  endtask

  task automatic wait_cnt(input int v);
    for (int i = 0; i < 40 && cnt_o != v; i++) tick();
  endtask

  task automatic setup(input int m0, input int m1, input int c0, input int c1,
                       input bit dn, input int rep);
    wr(3'd1, W'(c0));
    wr(3'd2, W'(c1));
    wr(3'd3, W'((m1 << 4) | m0));
    wr(3'd4, W'(rep));
    wr(3'd5, W'({dn, 1'b1}));
    force_upd();
  endtask

  // rows: mode0, mode1, cmp0, cmp1, down, expected ref0 highs, expected comb highs
  localparam int NROW = 11;
  localparam logic [40:0] VEC [NROW] = '{
    {4'd6,  4'd0, 8'd3,  8'd0, 1'b0, 8'd3,  8'd3},   // R5 PWM-A up
    {4'd6,  4'd0, 8'd3,  8'd0, 1'b1, 8'd4,  8'd4},   // R5 PWM-A down
    {4'd7,  4'd0, 8'd3,  8'd0, 1'b0, 8'd7,  8'd7},   // R5 PWM-B up
    {4'd7,  4'd0, 8'd3,  8'd0, 1'b1, 8'd6,  8'd6},   // R5 PWM-B down
    {4'd6,  4'd0, 8'd0,  8'd0, 1'b0, 8'd0,  8'd0},   // R5 compare zero
    {4'd6,  4'd0, 8'd12, 8'd0, 1'b0, 8'd10, 8'd10},  // R5 compare above period
    {4'd12, 4'd7, 8'd3,  8'd7, 1'b0, 8'd3,  8'd6},   // R10 OR
    {4'd13, 4'd6, 8'd3,  8'd7, 1'b0, 8'd7,  8'd4},   // R10 AND
    {4'd14, 4'd6, 8'd3,  8'd7, 1'b1, 8'd4,  8'd8},   // R11 down picks ref1
    {4'd14, 4'd6, 8'd3,  8'd7, 1'b0, 8'd3,  8'd3},   // R11 up picks ref0
    {4'd15, 4'd6, 8'd3,  8'd7, 1'b0, 8'd7,  8'd7}    // R11 mode B up
  };

  initial begin
    int hi, cb, gap, prev, tg;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 cnt", int'(cnt_o), 0);
    check("R1 ref", int'(ref_o), 0);
    check("R1 comb", int'(comb_o), 0);
    check("R1 update", int'(update_o), 0);
    rst_n = 1;

    wr(3'd0, W'(9));
    // R1: hold mode after reset keeps references low while counting
    wr(3'd5, W'(1));
    repeat (5) tick();
    check("R1 hold mode ref", int'(ref_o), 0);

    // table walk: R5 R10 R11
    for (int r = 0; r < NROW; r++) begin
      setup(int'(VEC[r][40:37]), int'(VEC[r][36:33]), int'(VEC[r][32:25]),
            int'(VEC[r][24:17]), VEC[r][16], 0);
      repeat (12) tick();
      hi = 0; cb = 0;
      for (int k = 0; k < 10; k++) begin
        tick();
        hi += int'(ref_o[0]);
        cb += int'(comb_o);
      end
      check($sformatf("R5/R10/R11 row%0d ref0 highs", r), hi, int'(VEC[r][15:8]));
      check($sformatf("R10/R11 row%0d comb highs", r), cb, int'(VEC[r][7:0]));
    end

    // R2: stop holds count, down counting visible
    setup(6, 0, 3, 0, 1'b0, 0);
    repeat (4) tick();
    wr(3'd5, W'(0));
    prev = int'(cnt_o);
    repeat (5) tick();
    check("R2 stopped count holds", int'(cnt_o), prev);
    wr(3'd5, W'(3));
    prev = int'(cnt_o);
    tick();
    check("R2 down step", int'(cnt_o), prev - 1);

    // R3: repetition spacing
    setup(6, 0, 3, 0, 1'b0, 2);
    for (int i = 0; i < 40 && !update_o; i++) tick();
    gap = 0;
    for (int i = 0; i < 40; i++) begin tick(); gap++; if (update_o) break; end
    check("R3 updates every 3 wraps", gap, 30);
    setup(6, 0, 3, 0, 1'b0, 0);
    gap = 0;
    for (int i = 0; i < 40; i++) begin tick(); gap++; if (update_o) break; end
    check("R3 update each wrap after force", gap, 10);

    // R4: shadowed compare
    setup(6, 0, 3, 0, 1'b0, 5);
    wr(3'd1, W'(6));
    repeat (10) tick();
    hi = 0;
    for (int k = 0; k < 10; k++) begin tick(); hi += int'(ref_o[0]); end
    check("R4 compare held until update", hi, 3);
    force_upd();
    repeat (10) tick();
    hi = 0;
    for (int k = 0; k < 10; k++) begin tick(); hi += int'(ref_o[0]); end
    check("R4 compare after update", hi, 6);

    // R6: match and force modes
    setup(3, 0, 5, 0, 1'b0, 0);
    repeat (2) tick();
    tg = 0; prev = int'(ref_o[0]);
    for (int k = 0; k < 20; k++) begin
      tick();
      if (int'(ref_o[0]) != prev) tg++;
      prev = int'(ref_o[0]);
    end
    check("R6 toggle per period", tg, 2);
    setup(4, 0, 5, 0, 1'b0, 0);
    repeat (2) tick();
    check("R6 force low", int'(ref_o[0]), 0);
    setup(1, 0, 5, 0, 1'b0, 0);
    repeat (12) tick();
    check("R6 set on match", int'(ref_o[0]), 1);
    setup(0, 0, 5, 0, 1'b0, 0);
    repeat (15) tick();
    check("R6 hold keeps level", int'(ref_o[0]), 1);
    setup(2, 0, 5, 0, 1'b0, 0);
    repeat (12) tick();
    check("R6 clear on match", int'(ref_o[0]), 0);
    setup(5, 0, 5, 0, 1'b0, 0);
    repeat (2) tick();
    check("R6 force high", int'(ref_o[0]), 1);

    // R7 + R9 up: idle high, trigger, retrigger
    setup(8, 0, 4, 0, 1'b0, 0);
    hi = 0;
    for (int k = 0; k < 12; k++) begin tick(); hi += int'(ref_o[0]); end
    check("R7 idle high up", hi, 12);
    wait_cnt(6);
    trig();
    check("R9 trigger restarts up", int'(cnt_o), 0);
    wait_cnt(2);
    trig();
    check("R9 retrigger restarts up", int'(cnt_o), 0);
    hi = 0;
    for (int k = 1; k <= 10; k++) begin tick(); hi += int'(ref_o[0]); end
    check("R7 window highs up", hi, 4);
    repeat (2) tick();
    check("R7 back to idle high", int'(ref_o[0]), 1);

    // R7 + R9 down
    setup(8, 0, 4, 0, 1'b1, 0);
    repeat (3) tick();
    check("R7 idle low down", int'(ref_o[0]), 0);
    wait_cnt(5);
    trig();
    check("R9 trigger restarts down", int'(cnt_o), 9);
    wait_cnt(7);
    trig();
    check("R9 retrigger restarts down", int'(cnt_o), 9);
    hi = 0;
    for (int k = 1; k <= 10; k++) begin tick(); hi += int'(ref_o[0]); end
    check("R7 window highs down", hi, 5);
    repeat (2) tick();
    check("R7 back to idle low", int'(ref_o[0]), 0);

    // R8 up
    setup(9, 0, 4, 0, 1'b0, 0);
    repeat (3) tick();
    check("R8 idle low up", int'(ref_o[0]), 0);
    wait_cnt(6);
    trig();
    hi = 0;
    for (int k = 1; k <= 10; k++) begin tick(); hi += int'(ref_o[0]); end
    check("R8 window highs up", hi, 6);
    repeat (2) tick();
    check("R8 back to idle low", int'(ref_o[0]), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule